// File: doc/BRIEF.md
# Bit-Band Alias Write Unit

This unit sits between a processor's simple request/ready bus master port and a word-addressed memory. A 32 MB alias window maps every 32-bit alias word onto one bit of a 1 MB target region. Writing an alias word sets or clears that single bit. Reading an alias word returns that single bit. The core never performs the read-modify-write for these writes. Instead, each alias write is posted into a four-entry write buffer and the core moves on. A sequencer inside the unit then reads the target word, modifies it and writes it back, where the core cannot see the work.

Accesses outside the alias window go directly to memory, and the core has priority on the memory port. The sequencer drains the buffer in the cycles the core leaves the port free. The core is held off in three cases:

- an alias write finds the buffer full;
- an alias read finds the buffer not yet empty;
- a plain access targets a word that still has a queued alias write.

This keeps every access to a word in program order.

Top module: `bitband_rmw_unit`

## Requirements
- R1: An address whose bits [31:25] match the alias base (default 0x2200_0000) is an alias access. With off = address − alias base, the target word is target base (default 0x2000_0000) + ((off >> 5) with its low two bits cleared), and the bit inside that word is off[6:2].
- R2: An alias write sets the selected target bit when bit 0 of the write data is 1 and clears it when bit 0 is 0. Bits [31:1] of the write data are ignored, and all other bits of the target word keep their values.
- R3: An alias read returns the selected bit in bit 0 of the read data, with bits [31:1] zero. The read data is valid with cpu_rvalid_o in the cycle after the read is accepted.
- R4: An alias read is not accepted until the write buffer is empty, so it observes every alias write accepted before it.
- R5: An alias write is accepted in the same cycle it is requested whenever the buffer has a free entry. Four back-to-back alias writes to an empty buffer never stall.
- R6: While four alias writes are pending, cpu_ready_o is low in the same cycle for a new alias write. The write is accepted once an entry drains, and no write is lost.
- R7: A plain access to a word with a pending alias write is held until that write has completed, so the plain write lands last. A plain access to any other word is not held.
- R8: A plain write stores its full word at its address. A plain read returns the stored word in the cycle after acceptance.
- R9: The sequencer steps IDLE, READ, MODIFY/WRITE, IDLE, with one buffer entry retired per sequence. After an alias write is accepted into an idle, empty unit, the memory port shows:
  - nothing in the first following cycle;
  - a read of the target word in the second;
  - the write of the modified word in the third.
  
  Only one requester drives the memory port in any cycle.
- R10: After reset, cpu_ready_o is high, cpu_rvalid_o is low and no memory request is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Core access request |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 32 | Core byte address |
| cpu_wdata_i | input | 32 | Core write data |
| cpu_ready_o | output | 1 | Access accepted at this edge when high with cpu_req_i |
| cpu_rvalid_o | output | 1 | Read data valid, one cycle after read acceptance |
| cpu_rdata_o | output | 32 | Read data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, one cycle after a read request |

## Verification
The bench writes alias words with junk in the upper data bits and checks neighbouring bits and words afterwards. A decoder that used the wrong offset bits would damage those neighbours, and a modifier that used the whole data word would flip the wrong bit. It issues an alias read directly after an alias write to the same bit. It also issues a plain write directly after an alias write to the same word. A design without the empty-buffer wait or the hazard hold would return stale data or let the late bit update overwrite the plain write. It fills the buffer with a back-to-back burst, expecting no stall on the first four writes, at least one stall later, and every bit landing. It then traces the memory port cycle by cycle for one alias write, which catches a sequencer that skips or reorders its read and write steps.

// File: rtl/bitband_pkg.sv
package bitband_pkg;
  parameter int unsigned ADDR_W = 32;
  parameter int unsigned DATA_W = 32;
  localparam int unsigned BIT_IDX_W = $clog2(DATA_W);

  typedef struct packed {
    logic [ADDR_W-1:0]    addr;
    logic [BIT_IDX_W-1:0] bidx;
    logic                 val;
  } bb_op_t;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_MODWR = 2'd2
  } seq_state_e;
endpackage

// File: rtl/bitband_decode.sv
module bitband_decode
  import bitband_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ALIAS_BASE      = 32'h2200_0000,
  parameter logic [ADDR_W-1:0] TARGET_BASE     = 32'h2000_0000,
  parameter int unsigned       ALIAS_SPAN_LOG2 = 25
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic                 is_alias_o,
  output logic [ADDR_W-1:0]    tgt_addr_o,
  output logic [BIT_IDX_W-1:0] bidx_o
);
  localparam int unsigned TGT_SPAN_LOG2 = ALIAS_SPAN_LOG2 - 5;

  logic [TGT_SPAN_LOG2-1:0] tgt_byte;
  logic [1:0]               unused_lsb;

  assign is_alias_o = (addr_i[ADDR_W-1:ALIAS_SPAN_LOG2] ==
                       ALIAS_BASE[ADDR_W-1:ALIAS_SPAN_LOG2]);
  // one alias word per target bit: 32 alias bytes per target byte
  assign tgt_byte   = addr_i[ALIAS_SPAN_LOG2-1:5];
  assign tgt_addr_o = TARGET_BASE + ADDR_W'(tgt_byte & ~TGT_SPAN_LOG2'(3));
  assign bidx_o     = addr_i[2 +: BIT_IDX_W];
  assign unused_lsb = addr_i[1:0];
endmodule

// File: rtl/bitband_wbuf.sv
module bitband_wbuf
  import bitband_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  bb_op_t            push_op_i,
  input  logic              pop_i,
  output bb_op_t            head_o,
  output logic              empty_o,
  output logic              full_o,
  input  logic [ADDR_W-3:0] probe_word_i,
  output logic              probe_hit_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  bb_op_t           slot_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] hit_vec;
  logic [PTR_W-1:0] wr_q, rd_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
    end else begin
      if (push_i) begin
        vld_q[wr_q] <= 1'b1;
        wr_q        <= bump(wr_q);
      end
      if (pop_i) begin
        vld_q[rd_q] <= 1'b0;
        rd_q        <= bump(rd_q);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) slot_q[wr_q] <= push_op_i;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_probe
    assign hit_vec[i] = vld_q[i] && (slot_q[i].addr[ADDR_W-1:2] == probe_word_i);
  end

  assign probe_hit_o = |hit_vec;
  assign head_o      = slot_q[rd_q];
  assign empty_o     = ~|vld_q;
  assign full_o      = &vld_q;
endmodule

// File: rtl/bitband_seq.sv
module bitband_seq
  import bitband_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              avail_i,
  input  bb_op_t            head_i,
  input  logic              port_busy_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              pop_o,
  output seq_state_e        state_o
);
  seq_state_e        state_q, state_d;
  logic              rd_pend_q;
  logic [DATA_W-1:0] word_q, cur_word, mask;

  always_comb begin
    state_d = state_q;
    req_o   = 1'b0;
    we_o    = 1'b0;
    pop_o   = 1'b0;
    unique case (state_q)
      SEQ_IDLE: if (avail_i) state_d = SEQ_READ;
      SEQ_READ: if (!port_busy_i) begin
        req_o   = 1'b1;
        state_d = SEQ_MODWR;
      end
      SEQ_MODWR: if (!port_busy_i) begin
        req_o   = 1'b1;
        we_o    = 1'b1;
        pop_o   = 1'b1;
        state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SEQ_IDLE;
      rd_pend_q <= 1'b0;
      word_q    <= '0;
    end else begin
      state_q   <= state_d;
      rd_pend_q <= (state_q == SEQ_READ) && !port_busy_i;
      if (rd_pend_q) word_q <= mem_rdata_i;
    end
  end

  // read data is live only in the cycle after the read; hold it if the write waits
  assign cur_word = rd_pend_q ? mem_rdata_i : word_q;
  assign mask     = {{(DATA_W-1){1'b0}}, 1'b1} << head_i.bidx;
  assign wdata_o  = head_i.val ? (cur_word | mask) : (cur_word & ~mask);
  assign addr_o   = head_i.addr;
  assign state_o  = state_q;
endmodule

// File: rtl/bitband_rmw_unit.sv
module bitband_rmw_unit
  import bitband_pkg::*;
#(
  parameter int unsigned       FIFO_DEPTH      = 4,
  parameter logic [ADDR_W-1:0] ALIAS_BASE      = 32'h2200_0000,
  parameter logic [ADDR_W-1:0] TARGET_BASE     = 32'h2000_0000,
  parameter int unsigned       ALIAS_SPAN_LOG2 = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic              cpu_rvalid_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic                 is_alias;
  logic [ADDR_W-1:0]    tgt_addr;
  logic [BIT_IDX_W-1:0] bidx;
  logic                 wbuf_full, wbuf_empty, wbuf_hit;
  logic                 accept, core_port, push;
  bb_op_t               push_op, head_op;
  logic                 seq_req, seq_we, seq_pop;
  logic [ADDR_W-1:0]    seq_addr;
  logic [DATA_W-1:0]    seq_wdata;
  seq_state_e           seq_state;
  logic                 rvalid_q, rd_alias_q;
  logic [BIT_IDX_W-1:0] rd_bidx_q;

  bitband_decode #(
    .ALIAS_BASE     (ALIAS_BASE),
    .TARGET_BASE    (TARGET_BASE),
    .ALIAS_SPAN_LOG2(ALIAS_SPAN_LOG2)
  ) u_decode (
    .addr_i    (cpu_addr_i),
    .is_alias_o(is_alias),
    .tgt_addr_o(tgt_addr),
    .bidx_o    (bidx)
  );

  // alias write: needs a slot; alias read: needs a drained buffer; plain: no word hazard
  assign cpu_ready_o = is_alias ? (cpu_we_i ? !wbuf_full : wbuf_empty) : !wbuf_hit;
  assign accept      = cpu_req_i && cpu_ready_o;
  assign push        = accept && is_alias && cpu_we_i;
  assign core_port   = accept && !(is_alias && cpu_we_i);
  assign push_op     = '{addr: tgt_addr, bidx: bidx, val: cpu_wdata_i[0]};

  bitband_wbuf #(.DEPTH(FIFO_DEPTH)) u_wbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_op_i   (push_op),
    .pop_i       (seq_pop),
    .head_o      (head_op),
    .empty_o     (wbuf_empty),
    .full_o      (wbuf_full),
    .probe_word_i(cpu_addr_i[ADDR_W-1:2]),
    .probe_hit_o (wbuf_hit)
  );

  bitband_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .avail_i    (!wbuf_empty),
    .head_i     (head_op),
    .port_busy_i(core_port),
    .mem_rdata_i(mem_rdata_i),
    .req_o      (seq_req),
    .we_o       (seq_we),
    .addr_o     (seq_addr),
    .wdata_o    (seq_wdata),
    .pop_o      (seq_pop),
    .state_o    (seq_state)
  );

  // core owns the port when it uses it; sequencer fills idle cycles
  assign mem_req_o   = core_port || seq_req;
  assign mem_we_o    = core_port ? cpu_we_i : seq_we;
  assign mem_addr_o  = core_port ? (is_alias ? tgt_addr : cpu_addr_i) : seq_addr;
  assign mem_wdata_o = core_port ? cpu_wdata_i : seq_wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q   <= 1'b0;
      rd_alias_q <= 1'b0;
      rd_bidx_q  <= '0;
    end else begin
      rvalid_q   <= accept && !cpu_we_i;
      rd_alias_q <= is_alias;
      rd_bidx_q  <= bidx;
    end
  end

  assign cpu_rvalid_o = rvalid_q;
  assign cpu_rdata_o  = rd_alias_q ? DATA_W'(mem_rdata_i[rd_bidx_q]) : mem_rdata_i;
endmodule

module bitband_rmw_chk
  import bitband_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cpu_req_i,
  input logic       cpu_we_i,
  input logic       cpu_ready_o,
  input logic       cpu_rvalid_o,
  input logic       is_alias,
  input logic       wbuf_full,
  input logic       wbuf_empty,
  input logic       wbuf_hit,
  input logic       core_port,
  input logic       seq_req,
  input logic       seq_pop,
  input logic       mem_req_o,
  input logic       mem_we_o,
  input seq_state_e seq_state
);
  // R6
  alias_full_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_we_i && is_alias && wbuf_full) |-> !cpu_ready_o);
  // R5
  alias_posted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_we_i && is_alias && !wbuf_full) |-> cpu_ready_o);
  // R4
  alias_rd_drained_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && !cpu_we_i && is_alias && cpu_ready_o) |-> wbuf_empty);
  // R7
  word_hazard_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && !is_alias && wbuf_hit) |-> !cpu_ready_o);
  // R9
  one_master_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(core_port && seq_req));
  // R9
  pop_with_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_pop |-> (mem_req_o && mem_we_o));
  // R9
  idle_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_state == SEQ_IDLE) |=> (seq_state == SEQ_IDLE || seq_state == SEQ_READ));
  // R9
  read_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_state == SEQ_READ) |=> (seq_state == SEQ_READ || seq_state == SEQ_MODWR));
  // R9
  modwr_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_state == SEQ_MODWR) |=> (seq_state == SEQ_MODWR || seq_state == SEQ_IDLE));
  // R3
  rvalid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_ready_o && !cpu_we_i) |=> cpu_rvalid_o);
endmodule

bind bitband_rmw_unit bitband_rmw_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_req_i   (cpu_req_i),
  .cpu_we_i    (cpu_we_i),
  .cpu_ready_o (cpu_ready_o),
  .cpu_rvalid_o(cpu_rvalid_o),
  .is_alias    (is_alias),
  .wbuf_full   (wbuf_full),
  .wbuf_empty  (wbuf_empty),
  .wbuf_hit    (wbuf_hit),
  .core_port   (core_port),
  .seq_req     (seq_req),
  .seq_pop     (seq_pop),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .seq_state   (seq_state)
);

// File: tb/bitband_rmw_unit_tb_top.sv
module bitband_rmw_unit_tb_top;
  localparam logic [31:0] A_BASE = 32'h2200_0000;
  localparam logic [31:0] T_BASE = 32'h2000_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpu_req_i = 1'b0, cpu_we_i = 1'b0;
  logic [31:0] cpu_addr_i = '0, cpu_wdata_i = '0;
  logic        cpu_ready_o, cpu_rvalid_o;
  logic [31:0] cpu_rdata_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [31:0] mem_rdata_i = '0;

  logic [31:0] mem_m [1024];
  logic [31:0] exp_m [1024];
  int nchk = 0, nfail = 0;

  always #4 clk_i = ~clk_i;

  bitband_rmw_unit dut_i (.*);

  always @(posedge clk_i) begin
    if (mem_req_o) begin
      if (mem_we_o) mem_m[mem_addr_o[11:2]] <= mem_wdata_o;
      else          mem_rdata_i <= mem_m[mem_addr_o[11:2]];
    end
  end

  function automatic logic [31:0] alias_of(input logic [31:0] t_off, input int b);
    return A_BASE + t_off * 32 + 32'(b) * 4;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // call at a negedge; returns at the negedge after acceptance with req still high
  task automatic xfer(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                      output logic [31:0] rd, output logic rv, output int stalls);
    cpu_req_i = 1'b1; cpu_we_i = we; cpu_addr_i = addr; cpu_wdata_i = wd;
    stalls = 0;
    #1;
    while (!cpu_ready_o) begin
      @(negedge clk_i); #1;
      stalls++;
    end
    @(negedge clk_i);
    rd = cpu_rdata_o;
    rv = cpu_rvalid_o;
  endtask

  task automatic go_idle(input int n);
    cpu_req_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic alias_set(input logic [31:0] t_off, input int b, input logic [31:0] wd, output int st);
    logic [31:0] rd; logic rv;
    xfer(1'b1, alias_of(t_off, b), wd, rd, rv, st);
    if (wd[0]) exp_m[t_off[11:2]] = exp_m[t_off[11:2]] | (32'h1 << b);
    else       exp_m[t_off[11:2]] = exp_m[t_off[11:2]] & ~(32'h1 << b);
  endtask

  task automatic plain_wr(input logic [31:0] t_off, input logic [31:0] wd, output int st);
    logic [31:0] rd; logic rv;
    xfer(1'b1, T_BASE + t_off, wd, rd, rv, st);
    exp_m[t_off[11:2]] = wd;
  endtask

  task automatic plain_rd_chk(input string tag, input logic [31:0] t_off);
    logic [31:0] rd; logic rv; int st;
    xfer(1'b0, T_BASE + t_off, '0, rd, rv, st);
    check({tag, " rvalid"}, {31'b0, rv}, 32'h1);
    check(tag, rd, exp_m[t_off[11:2]]);
  endtask

  task automatic test_reset();
    @(negedge clk_i);
    check("R10 ready after reset", {31'b0, cpu_ready_o}, 32'h1);
    check("R10 rvalid after reset", {31'b0, cpu_rvalid_o}, 32'h0);
    check("R10 no mem req after reset", {31'b0, mem_req_o}, 32'h0);
  endtask

  task automatic test_plain();
    int st;
    @(negedge clk_i);
    plain_wr(32'h100, 32'hA5A5_0001, st);
    plain_rd_chk("R8 plain readback", 32'h100);
    plain_rd_chk("R8 untouched word", 32'h200);
    go_idle(2);
  endtask

  task automatic test_alias_write();
    int st;
    @(negedge clk_i);
    alias_set(32'h040, 0, 32'h0000_0001, st);
    alias_set(32'h040, 31, 32'hFFFF_FFFE, st);   // upper data bits ignored: clears
    alias_set(32'h040, 17, 32'h0000_0003, st);
    alias_set(32'h7FC, 12, 32'h0000_0001, st);
    alias_set(32'h7FC, 5, 32'h8000_0000, st);
    plain_rd_chk("R2 R1 word 0x040 bits", 32'h040);
    plain_rd_chk("R2 R1 word 0x7FC bits", 32'h7FC);
    plain_rd_chk("R2 neighbour word 0x044", 32'h044);
    plain_rd_chk("R1 neighbour word 0x7F8", 32'h7F8);
    go_idle(2);
  endtask

  task automatic test_alias_read();
    logic [31:0] rd; logic rv; int st;
    @(negedge clk_i);
    plain_wr(32'h300, 32'h0000_0200, st);
    plain_wr(32'h304, 32'hFFFF_FFFF, st);
    xfer(1'b0, alias_of(32'h300, 9), '0, rd, rv, st);
    check("R3 alias read set bit", rd, 32'h1);
    check("R3 alias read rvalid", {31'b0, rv}, 32'h1);
    xfer(1'b0, alias_of(32'h300, 8), '0, rd, rv, st);
    check("R3 alias read clear bit", rd, 32'h0);
    xfer(1'b0, alias_of(32'h304, 31), '0, rd, rv, st);
    check("R3 alias read upper zero", rd, 32'h1);
    go_idle(2);
  endtask

  task automatic test_read_after_write();
    logic [31:0] rd; logic rv; int st;
    @(negedge clk_i);
    alias_set(32'h300, 9, 32'h0, st);
    xfer(1'b0, alias_of(32'h300, 9), '0, rd, rv, st);
    check("R4 alias read held behind write", {31'b0, st > 0}, 32'h1);
    check("R4 alias read sees queued write", rd, 32'h0);
    go_idle(2);
  endtask

  task automatic test_sequence();
    int st;
    logic [31:0] p;
    @(negedge clk_i);
    p = exp_m[32'h400 >> 2];
    alias_set(32'h400, 3, 32'h1, st);
    cpu_req_i = 1'b0; #1;
    check("R9 cycle1 port quiet", {31'b0, mem_req_o}, 32'h0);
    @(negedge clk_i); #1;
    check("R9 cycle2 read req/we", {30'b0, mem_req_o, mem_we_o}, 32'h2);
    check("R9 cycle2 read addr", mem_addr_o, T_BASE + 32'h400);
    @(negedge clk_i); #1;
    check("R9 cycle3 write req/we", {30'b0, mem_req_o, mem_we_o}, 32'h3);
    check("R9 cycle3 write data", mem_wdata_o, p | 32'h8);
    @(negedge clk_i); #1;
    check("R9 cycle4 port quiet", {31'b0, mem_req_o}, 32'h0);
    go_idle(1);
  endtask

  task automatic test_burst();
    int st[8];
    int total;
    @(negedge clk_i);
    for (int i = 0; i < 8; i++) alias_set(32'h500, i, 32'h1, st[i]);
    total = 0;
    for (int i = 0; i < 8; i++) total += st[i];
    check("R5 first four posted without stall", 32'(st[0] + st[1] + st[2] + st[3]), 32'h0);
    check("R6 full buffer stalls the core", {31'b0, total > 0}, 32'h1);
    plain_rd_chk("R6 all burst bits landed", 32'h500);
    go_idle(2);
  endtask

  task automatic test_hazard();
    int st;
    @(negedge clk_i);
    alias_set(32'h600, 4, 32'h1, st);
    plain_wr(32'h604, 32'hCAFE_0604, st);
    check("R7 other word not held", 32'(st), 32'h0);
    plain_wr(32'h600, 32'h1234_5678, st);
    check("R7 same word held", {31'b0, st > 0}, 32'h1);
    plain_rd_chk("R7 plain write lands last", 32'h600);
    plain_rd_chk("R7 other word stored", 32'h604);
    go_idle(2);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    nchk++; nfail++;
    $display("FAIL watchdog R1..all: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem_m[i] = 32'(i) * 32'h9E37_79B9;
      exp_m[i] = 32'(i) * 32'h9E37_79B9;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    test_reset();
    test_plain();
    test_alias_write();
    test_alias_read();
    test_read_after_write();
    test_sequence();
    test_burst();
    test_hazard();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule